// File: doc/BRIEF.md
# Display Brightness Duty and Blank Gating

This block decides, slot by slot, which of the character positions of a small dot-matrix display may drive their columns. It receives the stored control state, which is a 3-bit brightness code, a master blank bit and an override bit that turns off the software features. It also receives one blank-exempt bit per digit, an active-low hardware blank pin and the index of the current sub-slot inside a row period. From these it produces one registered enable per digit. The column drivers are gated by that enable.

Dimming is pulse-width based. Each row period is split into `2**SLOT_W` sub-slots, and a digit may only be lit while the sub-slot index is below a lit-slot count chosen by the brightness code. The counts follow a non-linear scale from full brightness down to a single slot. Blanking merges the hardware pin and the master blank bit. Digits marked exempt stay lit through both sources. When the override bit is set, the brightness code, the master blank and the exempt bits are all ignored, and only the pin can blank the display. The block holds no stored display data. Dimming and blanking only ever act on the enables.

Top module: `dim_gate`

## Requirements
- R1: While `rst_n` is low, `digit_en` is all zeros.
- R2: `digit_en` is registered. The value after a rising edge reflects the inputs sampled at that edge.
- R3: With `ext_off`=0 and no blanking, a digit is lit exactly while `slot` is below the lit count for `bright_code`. At `SLOT_W`=5, codes 0..7 give counts 32, 19, 13, 9, 5, 3, 2, 1. Code 0 is always lit, and code 7 is lit only at slot 0.
- R4: The brightness duty applies to every digit alike, including digits whose exempt bit is set.
- R5: With `ext_off`=0, a digit whose exempt bit is 0 is dark whenever `blank_n` is 0 or `mblank` is 1.
- R6: With `ext_off`=0, a digit whose exempt bit is 1 ignores both `blank_n` and `mblank`.
- R7: With `ext_off`=1 and `blank_n`=0, all digits are dark, whatever the values of `mblank` and `blank_exempt`.
- R8: With `ext_off`=1 and `blank_n`=1, all digits are lit in every slot, whatever the values of `bright_code`, `mblank` and `blank_exempt`.
- R9: Bit d of `blank_exempt` governs bit d of `digit_en`. Bit 0 is the rightmost digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bright_code | input | 3 | Brightness code, 0 = brightest, 7 = dimmest |
| mblank | input | 1 | Master blank from control state, 1 = blank |
| ext_off | input | 1 | Disables code, master blank and exempt bits |
| blank_exempt | input | NUM_DIGITS | Per-digit exemption from blanking |
| blank_n | input | 1 | Hardware blank pin, active low |
| slot | input | SLOT_W | Sub-slot index within the current row period |
| digit_en | output | NUM_DIGITS | Per-digit column-driver enable |

## Verification
The assertions check the following on every cycle: the override behaviour in both pin states, master blanking of non-exempt digits, full lighting of exempt digits at code 0, and the single-slot limit of the dimmest code. The exact lit-slot count of each intermediate brightness code is shown only by the bench, which counts lit slots over a whole row period. The same holds for the full cross of override, master blank, exempt pattern and pin, and for the mapping of exempt bits to digit positions.

// File: rtl/dim_pkg.sv
package dim_pkg;

   localparam int CODE_W      = 3;
   localparam int BASE_SLOT_W = 5;

   // lit-slot count for a 32-slot row period, per brightness code
   function automatic logic [BASE_SLOT_W:0] base_lit(input logic [CODE_W-1:0] code);
      logic [BASE_SLOT_W:0] n;
      case (code)
         3'd0:    n = 6'd32;
         3'd1:    n = 6'd19;
         3'd2:    n = 6'd13;
         3'd3:    n = 6'd9;
         3'd4:    n = 6'd5;
         3'd5:    n = 6'd3;
         3'd6:    n = 6'd2;
         default: n = 6'd1;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/dim_duty_gen.sv
module dim_duty_gen
   import dim_pkg::*;
#(
   parameter int SLOT_W = 5
) (
   input  logic [CODE_W-1:0] bright_code,
   input  logic              ext_off,
   input  logic [SLOT_W-1:0] slot,
   output logic              duty_on
);

   localparam int CNT_W = SLOT_W + 1;
   localparam int SHIFT = SLOT_W - BASE_SLOT_W;

   if (SLOT_W < BASE_SLOT_W) begin : g_bad_slot_w
      $error("dim_duty_gen: SLOT_W must be at least %0d", BASE_SLOT_W);
   end

   logic [CNT_W-1:0] lit_cnt;

   always_comb begin
      lit_cnt = CNT_W'(base_lit(bright_code)) << SHIFT;
      if (ext_off) duty_on = 1'b1;
      else         duty_on = ({1'b0, slot} < lit_cnt);
   end

endmodule

// File: rtl/dim_blank_combine.sv
module dim_blank_combine #(
   parameter int NUM_DIGITS = 4
) (
   input  logic                  blank_n,
   input  logic                  mblank,
   input  logic                  ext_off,
   input  logic [NUM_DIGITS-1:0] blank_exempt,
   output logic [NUM_DIGITS-1:0] digit_dark
);

   if (NUM_DIGITS < 1) begin : g_bad_digits
      $error("dim_blank_combine: NUM_DIGITS must be positive");
   end

   logic sw_blank;
   assign sw_blank = !blank_n || mblank;

   for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
      always_comb begin
         if (ext_off) digit_dark[d] = !blank_n;
         else         digit_dark[d] = sw_blank && !blank_exempt[d];
      end
   end

endmodule

// File: rtl/dim_gate.sv
module dim_gate
   import dim_pkg::*;
#(
   parameter int NUM_DIGITS = 4,
   parameter int SLOT_W     = 5,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2:0]            bright_code,
   input  logic                  mblank,
   input  logic                  ext_off,
   input  logic [NUM_DIGITS-1:0] blank_exempt,
   input  logic                  blank_n,
   input  logic [SLOT_W-1:0]     slot,
   output logic [NUM_DIGITS-1:0] digit_en
);

   logic                  duty_on;
   logic [NUM_DIGITS-1:0] digit_dark;
   logic [NUM_DIGITS-1:0] en_next;

   dim_duty_gen #(.SLOT_W(SLOT_W)) u_duty (
      .bright_code (bright_code),
      .ext_off     (ext_off),
      .slot        (slot),
      .duty_on     (duty_on)
   );

   dim_blank_combine #(.NUM_DIGITS(NUM_DIGITS)) u_blank (
      .blank_n      (blank_n),
      .mblank       (mblank),
      .ext_off      (ext_off),
      .blank_exempt (blank_exempt),
      .digit_dark   (digit_dark)
   );

   assign en_next = {NUM_DIGITS{duty_on}} & ~digit_dark;

   if (REG_OUT) begin : g_reg
      logic [NUM_DIGITS-1:0] en_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) en_q <= '0;
         else        en_q <= en_next;
      end
      assign digit_en = en_q;
   end else begin : g_comb
      assign digit_en = rst_n ? en_next : '0;
   end

endmodule

// File: rtl/dim_gate_chk.sv
module dim_gate_chk #(
   parameter int NUM_DIGITS = 4,
   parameter int SLOT_W     = 5,
   parameter bit REG_OUT    = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [2:0]            bright_code,
   input logic                  mblank,
   input logic                  ext_off,
   input logic [NUM_DIGITS-1:0] blank_exempt,
   input logic                  blank_n,
   input logic [SLOT_W-1:0]     slot,
   input logic [NUM_DIGITS-1:0] digit_en
);

   if (REG_OUT) begin : g_chk
      assert_override_pin_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (ext_off && !blank_n) |=> (digit_en == '0));

      assert_override_pin_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (ext_off && blank_n) |=> (digit_en == '1));

      assert_master_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (!ext_off && mblank) |=> ((digit_en & ~$past(blank_exempt)) == '0));

      assert_exempt_lit_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (!ext_off && bright_code == 3'd0)
            |=> ((digit_en & $past(blank_exempt)) == $past(blank_exempt)));

      assert_dimmest_one_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!ext_off && bright_code == 3'd7 && slot != '0) |=> (digit_en == '0));
   end

   always @(posedge clk) begin
      if (!rst_n) assert_reset_dark_R1: assert (digit_en == '0);
   end

endmodule

bind dim_gate dim_gate_chk #(
   .NUM_DIGITS (NUM_DIGITS),
   .SLOT_W     (SLOT_W),
   .REG_OUT    (REG_OUT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bright_code  (bright_code),
   .mblank       (mblank),
   .ext_off      (ext_off),
   .blank_exempt (blank_exempt),
   .blank_n      (blank_n),
   .slot         (slot),
   .digit_en     (digit_en)
);

// File: tb/dim_gate_bench.sv
module dim_gate_bench;

   localparam int ND = 4;
   localparam int SW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    bright_code = '0;
   logic          mblank = 1'b0;
   logic          ext_off = 1'b0;
   logic [ND-1:0] blank_exempt = '0;
   logic          blank_n = 1'b1;
   logic [SW-1:0] slot = '0;
   logic [ND-1:0] digit_en;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   dim_gate #(.NUM_DIGITS(ND), .SLOT_W(SW)) u_dim_gate (
      .clk (clk), .rst_n (rst_n), .bright_code (bright_code), .mblank (mblank),
      .ext_off (ext_off), .blank_exempt (blank_exempt), .blank_n (blank_n),
      .slot (slot), .digit_en (digit_en)
   );

   function automatic int exp_count(input int code);
      int t [8] = '{32, 19, 13, 9, 5, 3, 2, 1};
      return t[code];
   endfunction

   function automatic logic [ND-1:0] model(input logic eo, input logic mb,
      input logic [ND-1:0] ex, input logic bn, input int code, input int s);
      logic [ND-1:0] r;
      for (int d = 0; d < ND; d++) begin
         if (eo) r[d] = bn;
         else    r[d] = (s < exp_count(code)) && (ex[d] || (bn && !mb));
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive at the falling edge, sample just after the next rising edge
   task automatic apply(input logic eo, input logic mb, input logic [ND-1:0] ex,
                        input logic bn, input int code, input int s);
      @(negedge clk);
      ext_off = eo; mblank = mb; blank_exempt = ex; blank_n = bn;
      bright_code = 3'(code); slot = SW'(s);
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst_n = 1'b0; ext_off = 1'b1; blank_n = 1'b1;
      @(posedge clk); #1;
      check(digit_en == '0, "R1 reset dark", digit_en, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check(digit_en == '1, "R2 first edge after reset", digit_en, 4'hF);
   endtask

   task automatic t_duty_sweep;
      for (int code = 0; code < 8; code++) begin
         int lit = 0;
         bit prefix_ok = 1;
         for (int s = 0; s < 32; s++) begin
            apply(1'b0, 1'b0, 4'b0101, 1'b1, code, s);
            if (digit_en == '1) lit++;
            else if (digit_en != '0) prefix_ok = 0;
            if ((digit_en == '1) != (s < exp_count(code))) prefix_ok = 0;
         end
         check(lit == exp_count(code), "R3 lit slot count", lit, exp_count(code));
         check(prefix_ok, "R4 same duty on all digits, lit from slot 0", prefix_ok, 1);
      end
   endtask

   task automatic t_blank_sweep;
      for (int eo = 0; eo < 2; eo++)
         for (int mb = 0; mb < 2; mb++)
            for (int ex = 0; ex < 16; ex++)
               for (int bn = 0; bn < 2; bn++) begin
                  logic [ND-1:0] e;
                  int code;
                  int s;
                  code = eo ? 6 : 0;   // code must not matter under override
                  s    = eo ? 20 : 5;
                  apply(eo[0], mb[0], ex[3:0], bn[0], code, s);
                  e = model(eo[0], mb[0], ex[3:0], bn[0], code, s);
                  if (eo != 0)
                     check(digit_en == e, bn ? "R8 override lit" : "R7 override pin blank",
                           digit_en, e);
                  else
                     check(digit_en == e, "R5/R6 blank combine with exempt", digit_en, e);
               end
   endtask

   task automatic t_dim_exempt;
      // pin low, exempt digits 1 and 2, code 2 (13 slots): R4 and R6 together
      apply(1'b0, 1'b1, 4'b0110, 1'b0, 2, 12);
      check(digit_en == 4'b0110, "R6 exempt lit under both sources", digit_en, 4'b0110);
      apply(1'b0, 1'b1, 4'b0110, 1'b0, 2, 13);
      check(digit_en == 4'b0000, "R4 exempt digit still dimmed", digit_en, 0);
   endtask

   task automatic t_digit_order;
      for (int d = 0; d < ND; d++) begin
         apply(1'b0, 1'b1, 4'(1 << d), 1'b1, 0, 0);
         check(digit_en == 4'(1 << d), "R9 exempt bit maps to digit", digit_en, 1 << d);
      end
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset;
      t_duty_sweep;
      t_blank_sweep;
      t_dim_exempt;
      t_digit_order;
      finish_run;
   end

   initial begin
      #(8 * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run;
   end

endmodule